// File: doc/BRIEF.md
# Doorbell and Software-Trigger Unit

This block holds a 32-bit doorbell cause register and a 32-bit doorbell mask register for each CPU. Processors use it to interrupt one another. External agents use it to post message-signalled interrupts. One write to the trigger register names a doorbell number and a bitmap of target CPUs. That write raises the doorbell in the cause register of every CPU whose bit is set in the bitmap.

The cause and mask registers are reached through a simple register bus. A CPU-ID sideband input selects which CPU's copy a write or read touches. A CPU acknowledges doorbells by writing its cause register. Every bit written as 0 is cleared and every bit written as 1 keeps its value, so writing the complement of the bits just read acknowledges exactly those bits.

Each CPU gets two summary interrupt lines. The inter-processor line covers doorbells 0 to 7 and the message-signalled line covers doorbells 16 to 31. Each line is asserted while any unmasked cause bit in its group is pending. These lines feed the first two sources of the CPU's interrupt controller.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every cause and mask register reads 0 and all summary outputs are low.
- R2: A write to offset 0x04 sets cause bit `wdata[4:0]` of every CPU c whose target bit `wdata[8+c]` is 1. Target bits occupy `wdata[11:8]`.
- R3: A trigger write whose target bitmap is all zero changes no cause register.
- R4: A write to offset 0x08 applies only to the CPU given by the CPU-ID input. The new cause value is the old value ANDed with the write data. The cause registers of other CPUs are unchanged.
- R5: Writing 0 to offset 0x08 clears every pending doorbell of that CPU.
- R6: A write to offset 0x0C loads that CPU's mask register, and a read of 0x0C returns it. A read of 0x08 returns that CPU's cause register.
- R7: `ipi_irq[c]` is high exactly when some bit in [7:0] is set in both the cause and the mask of CPU c. The output follows the register update after one clock edge.
- R8: `msi_irq[c]` is high exactly when some bit in [31:16] is set in both the cause and the mask of CPU c. Doorbells 8 to 15 drive neither output.
- R9: A trigger value of `0xF00 | (16+n)`, with n in 0..15, sets cause bit 16+n on all four CPUs.
- R10: A read of any offset other than 0x08 or 0x0C returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Requesting CPU, selects the per-CPU copy |
| bus_rdata | output | 32 | Combinational read data |
| ipi_irq | output | NCPU | Per-CPU inter-processor summary line |
| msi_irq | output | NCPU | Per-CPU message-signalled summary line |

## Verification
The bench builds the block with NCPU = 4 and ADDR_W = 8. That is the widest configuration the 4-bit target field can address, so every bitmap position, including the all-CPU broadcast used for message-signalled interrupts, is exercised. The four CPUs are given different masks: full, inter-processor only, message-signalled only, and the unused band 8 to 15 only. This lets one pending doorbell show up on some summary lines and stay hidden on others in the same cycle. A behavioural model compares both summary vectors against the design every clock.

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 8,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [CPU_W-1:0]  bus_cpu,
  output logic [31:0]       bus_rdata,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   msi_irq
);
  localparam logic [ADDR_W-1:0] TRIG_OFS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CAUSE_OFS = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] MASK_OFS  = ADDR_W'(12);

  logic [31:0] cause_q [NCPU];
  logic [31:0] mask_q  [NCPU];

  wire         trig_hit  = bus_wr && (bus_addr == TRIG_OFS);
  wire         cause_hit = bus_wr && (bus_addr == CAUSE_OFS);
  wire         mask_hit  = bus_wr && (bus_addr == MASK_OFS);
  wire  [31:0] db_bit    = 32'h1 << bus_wdata[4:0];

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wire        own   = (bus_cpu == CPU_W'(c));
    wire [31:0] keep  = (cause_hit && own) ? bus_wdata : '1;
    wire [31:0] raise = (trig_hit && bus_wdata[8+c]) ? db_bit : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cause_q[c] <= '0;
        mask_q[c]  <= '0;
      end else begin
        cause_q[c] <= (cause_q[c] & keep) | raise;
        if (mask_hit && own) mask_q[c] <= bus_wdata;
      end
    end

    assign ipi_irq[c] = |(cause_q[c][7:0]   & mask_q[c][7:0]);
    assign msi_irq[c] = |(cause_q[c][31:16] & mask_q[c][31:16]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (bus_cpu == CPU_W'(c)) begin
        if (bus_addr == CAUSE_OFS) bus_rdata = cause_q[c];
        else if (bus_addr == MASK_OFS) bus_rdata = mask_q[c];
      end
    end
  end
endmodule

// File: rtl/doorbell_unit_chk.sv
module doorbell_unit_chk #(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 8,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [CPU_W-1:0]  bus_cpu,
  input logic [NCPU-1:0]   ipi_irq,
  input logic [NCPU-1:0]   msi_irq,
  input logic [31:0]       cause_q [NCPU],
  input logic [31:0]       mask_q  [NCPU]
);
  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[8+c]) |=> cause_q[c][$past(bus_wdata[4:0])]); // R2
    AST_UNTARGETED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(4) && !bus_wdata[8+c]) |=> $stable(cause_q[c])); // R3
    AST_ACK_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(8)) |=> ((cause_q[c] & ~$past(cause_q[c])) == 32'h0)); // R4
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(12) && bus_cpu == CPU_W'(c)) |=> (mask_q[c] == $past(bus_wdata))); // R6
    AST_IPI_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[c][7:0] == 8'h0) |-> !ipi_irq[c]); // R7
    AST_MSI_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[c][31:16] == 16'h0) |-> !msi_irq[c]); // R8
  end
endmodule

bind doorbell_unit doorbell_unit_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .ipi_irq(ipi_irq),
  .msi_irq(msi_irq), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/doorbell_unit_tb.sv
module doorbell_unit_tb;
  localparam int NCPU = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0] bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NCPU-1:0] ipi_irq, msi_irq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;
  logic [31:0] m_cause [NCPU];
  logic [31:0] m_mask  [NCPU];

  always #10 clk = ~clk;

  doorbell_unit #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
    .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: behavioural update on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) begin m_cause[c] = 0; m_mask[c] = 0; end
    end else if (bus_wr) begin
      for (int c = 0; c < NCPU; c++) begin
        if (bus_addr == 8'h08 && int'(bus_cpu) == c) m_cause[c] = m_cause[c] & bus_wdata;
        if (bus_addr == 8'h0C && int'(bus_cpu) == c) m_mask[c] = bus_wdata;
        if (bus_addr == 8'h04 && bus_wdata[8+c]) m_cause[c][bus_wdata[4:0]] = 1'b1;
      end
    end
  end

  // per-clock comparison of the summary lines (R7, R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCPU-1:0] ei, em;
      for (int c = 0; c < NCPU; c++) begin
        ei[c] = |(m_cause[c][7:0] & m_mask[c][7:0]);
        em[c] = |(m_cause[c][31:16] & m_mask[c][31:16]);
      end
      chk("R7 ipi_irq", 32'(ipi_irq), 32'(ei));
      chk("R8 msi_irq", 32'(msi_irq), 32'(em));
    end
  end

  task automatic wr(input logic [7:0] a, input int cpu, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_cpu = 2'(cpu); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int cpu, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_cpu = 2'(cpu);
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    failed++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCPU; c++) begin
      rd(8'h08, c, 32'h0, "R1 cause after reset");
      rd(8'h0C, c, 32'h0, "R1 mask after reset");
    end
    chk("R1 summaries after reset", 32'({ipi_irq, msi_irq}), 32'h0);

    wr(8'h0C, 0, 32'hFFFF00FF);
    wr(8'h0C, 1, 32'h000000FF);
    wr(8'h0C, 2, 32'hFFFF0000);
    wr(8'h0C, 3, 32'h0000FF00);
    rd(8'h0C, 0, 32'hFFFF00FF, "R6 mask readback cpu0");
    rd(8'h0C, 3, 32'h0000FF00, "R6 mask readback cpu3");

    wr(8'h04, 0, 32'h00000303);
    rd(8'h08, 0, 32'h00000008, "R2 cpu0 targeted");
    rd(8'h08, 1, 32'h00000008, "R2 cpu1 targeted");
    rd(8'h08, 2, 32'h00000000, "R2 cpu2 untargeted");
    chk("R7 ipi after trigger", 32'(ipi_irq), 32'h3);

    wr(8'h04, 0, 32'h00000005);
    for (int c = 0; c < NCPU; c++)
      rd(8'h08, c, (c < 2) ? 32'h8 : 32'h0, "R3 empty bitmap");

    wr(8'h04, 1, 32'h00000F00 | (16 + 7));
    for (int c = 0; c < NCPU; c++)
      rd(8'h08, c, (c < 2) ? 32'h00800008 : 32'h00800000, "R9 msi broadcast");
    chk("R8 msi per mask", 32'(msi_irq), 32'h5);

    wr(8'h04, 0, 32'h0000080C);
    rd(8'h08, 3, 32'h00801000, "R2 gap doorbell cpu3");
    chk("R8 gap band silent ipi", 32'(ipi_irq[3]), 32'h0);
    chk("R8 gap band silent msi", 32'(msi_irq[3]), 32'h0);

    bus_cpu = 2'd0;
    wr(8'h08, 0, ~32'h00000008);
    rd(8'h08, 0, 32'h00800000, "R4 ack one bit");
    rd(8'h08, 1, 32'h00800008, "R4 other cpu untouched");
    chk("R7 ipi after ack", 32'(ipi_irq), 32'h2);

    wr(8'h08, 1, 32'h0);
    rd(8'h08, 1, 32'h0, "R5 clear all");

    rd(8'h10, 0, 32'h0, "R10 unmapped offset");
    rd(8'h04, 0, 32'h0, "R10 trigger reads zero");

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule